// File: doc/BRIEF.md
# Extended Interrupt Vector Router

This block gathers a large set of level-sensitive interrupt lines, 256 by default, arranged in groups of 32, and steers each of them to one interrupt pin on one core. Every vector has three bits of state. A raw level bit follows the input. An enable bit is set by software. A status bit belongs to the core the vector is routed to, and it is raised when an enabled vector goes high. The block drives one level output for each (core, pin) pair. An output is high while any vector steered to it holds its status bit.

Software reaches the block through a 32-bit word port. The address is 16 bits; bits [1:0] are ignored and data is little-endian. Through this port software writes enable words, clears status bits by writing ones, and sets two selector maps. The core map holds one byte per vector and the pin map holds one byte per group. Two further ranges, named node-type and bounce, are only stored and read back. When an enable word or a core selector changes, vectors that are already pending are replayed at once, so that no edge is lost.

Top module: `evr_vector_router`

## Requirements
- R1: A rising input is always recorded in the raw level bit. It sets the status bit on its routed core only when its enable bit (enable word g at 0x500 + 4·g, bit v mod 32) is 1.
- R2: Output bit core·4 + pin is high while at least one vector routed to that (core, pin) pair holds its status bit. It goes low only when the last such bit clears.
- R3: An enable write acts only on bits that change. A bit going 0→1 whose raw level is high sets that vector's status bit. A bit going 1→0 clears it. Bits that do not change keep their status.
- R4: Writing a status word clears each status bit written as 1 and leaves the bits written as 0. A vector whose input stays high stays cleared until its next rising edge.
- R5: Status words lie in 0x000–0x3FF. Bits [9:8] give the core and bits [4:2] give the group. Addresses in this range with any of bits [7:5] set are undecoded.
- R6: When an input falls, its status bit is removed in the same cycle that its raw bit clears, and so is its share of the routed output.
- R7: The core map word at 0x800 + 4·w holds byte k (bits 8k+7:8k) for vector 4w+k. The pin map words at 0x400 and 0x404 hold byte g for group g in the same way. In each byte the lowest set bit selects the core or pin. A zero byte, or a lowest set bit of 4 or more, selects 0.
- R8: A core map write that changes a vector's decoded core clears that vector's status everywhere. If the vector is pending and enabled, its status is then set on the new core.
- R9: Reads return the stored word for the enable, status, pin map, core map, node-type (0x480, 4 words) and bounce (0x580, one word per group) ranges. Any other address reads zero, and a write to it changes nothing.
- R10: With default parameters, outputs change in the first clock edge after the input change or register write that causes them.
- R11: Reset clears all level, enable and status bits, all map and stored words, and all outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_in | input | NUM_VEC | Level interrupt inputs, one per vector |
| reg_wr | input | 1 | Write strobe for the word port |
| reg_addr | input | 16 | Byte address of the word access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_out | output | NUM_CORES·NUM_PINS | Level output, bit index core·NUM_PINS + pin |

## Verification
The hardest state to reach from the ports is a pending vector whose status was cleared by software or was never set, and which is then replayed by an enable change or a core remap. The stimulus holds an input high while the vector is disabled, or clears its status with a write-one while the input stays high. It then toggles enable bits or rewrites the core selector. Each time it checks that only the changed bits act and that the output moves to the new (core, pin) output. Invalid selector bytes and stray status addresses with bits [7:5] set are also driven, to show that they fall back to 0 or decode as empty.

// File: rtl/evr_pkg.sv
package evr_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned ADDR_W = 16;

   // address ranges of the word port (low 16 address bits)
   localparam logic [15:0] PIN_BASE  = 16'h0400;
   localparam logic [15:0] NODE_BASE = 16'h0480;
   localparam logic [15:0] EN_BASE   = 16'h0500;
   localparam logic [15:0] BNC_BASE  = 16'h0580;
   localparam logic [15:0] CORE_BASE = 16'h0800;
   localparam int unsigned PIN_WORDS = 2;

   typedef enum logic [2:0] {
      RK_NONE, RK_STAT, RK_PIN, RK_NODE, RK_EN, RK_BNC, RK_CORE
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e  kind;
      logic [5:0] word;
      logic [1:0] core;
   } reg_hit_t;

   // lowest set bit of a selector byte; none or out of range selects 0
   function automatic logic [1:0] sel_from_byte(input logic [7:0] b,
                                                input int unsigned limit);
      logic [1:0] r;
      logic       found;
      r     = '0;
      found = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (!found && b[i]) begin
            found = 1'b1;
            if (i < int'(limit)) r = i[1:0];
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/evr_addr_decode.sv
module evr_addr_decode
   import evr_pkg::*;
#(
   parameter int unsigned GROUPS     = 8,
   parameter int unsigned CORES      = 4,
   parameter int unsigned NODE_WORDS = 4,
   parameter int unsigned CORE_WORDS = 64
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_hit_t          hit
);

   logic unused_low;
   assign unused_low = ^addr[1:0];

   function automatic logic in_rng(input logic [15:0] a,
                                   input logic [15:0] base,
                                   input int unsigned cnt);
      logic [31:0] aa, lo, hi;
      aa = {16'b0, a};
      lo = {16'b0, base};
      hi = lo + (cnt << 2);
      return (aa >= lo) && (aa < hi);
   endfunction

   always_comb begin
      hit = '0;
      if (addr[15:10] == 6'd0) begin
         if (addr[7:5] == 3'd0 && 32'(addr[4:2]) < GROUPS &&
             32'(addr[9:8]) < CORES) begin
            hit.kind = RK_STAT;
            hit.word = {3'd0, addr[4:2]};
            hit.core = addr[9:8];
         end
      end else if (in_rng(addr, PIN_BASE, PIN_WORDS)) begin
         hit.kind = RK_PIN;
         hit.word = 6'((addr - PIN_BASE) >> 2);
      end else if (in_rng(addr, NODE_BASE, NODE_WORDS)) begin
         hit.kind = RK_NODE;
         hit.word = 6'((addr - NODE_BASE) >> 2);
      end else if (in_rng(addr, EN_BASE, GROUPS)) begin
         hit.kind = RK_EN;
         hit.word = 6'((addr - EN_BASE) >> 2);
      end else if (in_rng(addr, BNC_BASE, GROUPS)) begin
         hit.kind = RK_BNC;
         hit.word = 6'((addr - BNC_BASE) >> 2);
      end else if (in_rng(addr, CORE_BASE, CORE_WORDS)) begin
         hit.kind = RK_CORE;
         hit.word = 6'((addr - CORE_BASE) >> 2);
      end
   end

endmodule

// File: rtl/evr_group_slice.sv
module evr_group_slice #(
   parameter int unsigned CORES = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [31:0]            vec_lvl,
   input  logic [31:0][1:0]       core_sel,
   input  logic                   en_we,
   input  logic [31:0]            en_wdata,
   input  logic                   clr_we,
   input  logic [1:0]             clr_core,
   input  logic [31:0]            clr_mask,
   input  logic [31:0]            mv_mask,
   input  logic [31:0][1:0]       mv_core,
   output logic [31:0]            raw_q,
   output logic [31:0]            en_q,
   output logic [CORES-1:0][31:0] stat_q
);

   logic [31:0]            en_nx;
   logic [CORES-1:0][31:0] stat_d;

   assign en_nx = en_we ? en_wdata : en_q;

   for (genvar v = 0; v < 32; v++) begin : g_vec
      logic [1:0]       tgt;
      logic [CORES-1:0] cur;
      logic [CORES-1:0] nxt;

      always_comb begin
         tgt = mv_mask[v] ? mv_core[v] : core_sel[v];
         for (int c = 0; c < CORES; c++) cur[c] = stat_q[c][v];
         nxt = cur;
         // remap: drop everywhere, replay on the new core
         if (mv_mask[v]) begin
            nxt = '0;
            if (raw_q[v] && en_q[v]) nxt[tgt] = 1'b1;
         end
         // enable edges replay or withdraw
         if (en_we && en_wdata[v] && !en_q[v] && raw_q[v]) nxt[tgt] = 1'b1;
         if (en_we && !en_wdata[v] && en_q[v]) nxt[tgt] = 1'b0;
         // software write-one-to-clear
         if (clr_we && clr_mask[v]) nxt[clr_core] = 1'b0;
         // input edges
         if (vec_lvl[v] && !raw_q[v] && en_nx[v]) nxt[tgt] = 1'b1;
         if (!vec_lvl[v] && raw_q[v]) nxt = '0;
      end

      for (genvar c = 0; c < CORES; c++) begin : g_core
         assign stat_d[c][v] = nxt[c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q  <= '0;
         en_q   <= '0;
         stat_q <= '0;
      end else begin
         raw_q  <= vec_lvl;
         en_q   <= en_nx;
         stat_q <= stat_d;
      end
   end

endmodule

// File: rtl/evr_pin_merge.sv
module evr_pin_merge #(
   parameter int unsigned GROUPS = 8,
   parameter int unsigned CORES  = 4,
   parameter int unsigned PINS   = 4
) (
   input  logic [GROUPS-1:0][CORES-1:0][31:0] stat_all,
   input  logic [GROUPS-1:0][1:0]             pin_sel,
   output logic [CORES*PINS-1:0]              irq
);

   for (genvar c = 0; c < CORES; c++) begin : g_core
      for (genvar p = 0; p < PINS; p++) begin : g_pin
         logic any_hit;
         always_comb begin
            any_hit = 1'b0;
            for (int g = 0; g < GROUPS; g++) begin
               if (pin_sel[g] == 2'(p) && (|stat_all[g][c])) any_hit = 1'b1;
            end
         end
         assign irq[c*PINS+p] = any_hit;
      end
   end

endmodule

// File: rtl/evr_vector_router.sv
module evr_vector_router
   import evr_pkg::*;
#(
   parameter int unsigned NUM_VEC    = 256,
   parameter int unsigned NUM_CORES  = 4,
   parameter int unsigned NUM_PINS   = 4,
   parameter int unsigned NODE_WORDS = 4,
   parameter bit          OUT_FLOP   = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_VEC-1:0]           vec_in,
   input  logic                         reg_wr,
   input  logic [15:0]                  reg_addr,
   input  logic [31:0]                  reg_wdata,
   output logic [31:0]                  reg_rdata,
   output logic [NUM_CORES*NUM_PINS-1:0] irq_out
);

   localparam int unsigned GROUPS     = NUM_VEC / 32;
   localparam int unsigned CORE_WORDS = NUM_VEC / 4;
   localparam int unsigned GW         = $clog2(GROUPS);
   localparam int unsigned CW         = $clog2(NUM_CORES);
   localparam int unsigned CWW        = $clog2(CORE_WORDS);
   localparam int unsigned NW         = $clog2(NODE_WORDS);
   localparam int unsigned NOUT       = NUM_CORES * NUM_PINS;

   // elaboration-time parameter checks
   if (NUM_VEC % 32 != 0 || NUM_VEC < 64 || NUM_VEC > 256) begin : g_bad_vec
      $error("NUM_VEC must be a multiple of 32 from 64 to 256");
   end
   if (NUM_CORES < 2 || NUM_CORES > 4) begin : g_bad_cores
      $error("NUM_CORES must be 2 to 4");
   end
   if (NUM_PINS < 2 || NUM_PINS > 4) begin : g_bad_pins
      $error("NUM_PINS must be 2 to 4");
   end
   if (NODE_WORDS < 2 || NODE_WORDS > 32 || (1 << NW) != NODE_WORDS) begin : g_bad_node
      $error("NODE_WORDS must be a power of two from 2 to 32");
   end

   reg_hit_t hit;

   logic [PIN_WORDS-1:0][31:0]  pin_words;
   logic [NODE_WORDS-1:0][31:0] node_words;
   logic [GROUPS-1:0][31:0]     bnc_words;
   logic [CORE_WORDS-1:0][31:0] core_words;

   logic [NUM_VEC-1:0][1:0]     core_sel;
   logic [NUM_VEC-1:0][1:0]     mv_core;
   logic [NUM_VEC-1:0]          mv_mask;
   logic [GROUPS-1:0][1:0]      pin_sel;

   logic [GROUPS-1:0][31:0]                raw_all;
   logic [GROUPS-1:0][31:0]                en_all;
   logic [GROUPS-1:0][NUM_CORES-1:0][31:0] stat_all;
   logic [NOUT-1:0]                        irq_c;

   logic core_wr;
   assign core_wr = reg_wr && (hit.kind == RK_CORE);

   evr_addr_decode #(
      .GROUPS     (GROUPS),
      .CORES      (NUM_CORES),
      .NODE_WORDS (NODE_WORDS),
      .CORE_WORDS (CORE_WORDS)
   ) u_dec (
      .addr (reg_addr),
      .hit  (hit)
   );

   // stored configuration words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_words  <= '0;
         node_words <= '0;
         bnc_words  <= '0;
         core_words <= '0;
      end else if (reg_wr) begin
         case (hit.kind)
            RK_PIN:  pin_words[hit.word[0]]        <= reg_wdata;
            RK_NODE: node_words[hit.word[NW-1:0]]  <= reg_wdata;
            RK_BNC:  bnc_words[hit.word[GW-1:0]]   <= reg_wdata;
            RK_CORE: core_words[hit.word[CWW-1:0]] <= reg_wdata;
            default: ;
         endcase
      end
   end

   // per-vector core selector and remap detection
   for (genvar v = 0; v < NUM_VEC; v++) begin : g_map
      logic [1:0] new_sel;
      assign core_sel[v] = sel_from_byte(core_words[v/4][8*(v%4) +: 8], NUM_CORES);
      assign new_sel     = sel_from_byte(reg_wdata[8*(v%4) +: 8], NUM_CORES);
      assign mv_mask[v]  = core_wr && (hit.word[CWW-1:0] == CWW'(v/4)) &&
                           (new_sel != core_sel[v]);
      assign mv_core[v]  = new_sel;
   end

   // per-group pin selector
   for (genvar g = 0; g < GROUPS; g++) begin : g_pinsel
      assign pin_sel[g] = sel_from_byte(pin_words[g/4][8*(g%4) +: 8], NUM_PINS);
   end

   // vector state, one slice per 32-bit group
   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic en_we_g;
      logic clr_we_g;
      assign en_we_g  = reg_wr && (hit.kind == RK_EN)   && (hit.word[GW-1:0] == GW'(g));
      assign clr_we_g = reg_wr && (hit.kind == RK_STAT) && (hit.word[GW-1:0] == GW'(g));

      evr_group_slice #(
         .CORES (NUM_CORES)
      ) u_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .vec_lvl  (vec_in[32*g +: 32]),
         .core_sel (core_sel[32*g +: 32]),
         .en_we    (en_we_g),
         .en_wdata (reg_wdata),
         .clr_we   (clr_we_g),
         .clr_core (hit.core),
         .clr_mask (reg_wdata),
         .mv_mask  (mv_mask[32*g +: 32]),
         .mv_core  (mv_core[32*g +: 32]),
         .raw_q    (raw_all[g]),
         .en_q     (en_all[g]),
         .stat_q   (stat_all[g])
      );
   end

   evr_pin_merge #(
      .GROUPS (GROUPS),
      .CORES  (NUM_CORES),
      .PINS   (NUM_PINS)
   ) u_merge (
      .stat_all (stat_all),
      .pin_sel  (pin_sel),
      .irq      (irq_c)
   );

   // output variant: straight from state, or one extra flop stage
   if (OUT_FLOP) begin : g_out_flop
      logic [NOUT-1:0] irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= '0;
         else        irq_q <= irq_c;
      end
      assign irq_out = irq_q;
   end else begin : g_out_comb
      assign irq_out = irq_c;
   end

   // read path
   always_comb begin
      reg_rdata = '0;
      case (hit.kind)
         RK_STAT: reg_rdata = stat_all[hit.word[GW-1:0]][hit.core[CW-1:0]];
         RK_PIN:  reg_rdata = pin_words[hit.word[0]];
         RK_NODE: reg_rdata = node_words[hit.word[NW-1:0]];
         RK_EN:   reg_rdata = en_all[hit.word[GW-1:0]];
         RK_BNC:  reg_rdata = bnc_words[hit.word[GW-1:0]];
         RK_CORE: reg_rdata = core_words[hit.word[CWW-1:0]];
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/evr_router_chk.sv
module evr_router_chk #(
   parameter int unsigned NUM_VEC   = 256,
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned NUM_PINS  = 4
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [NUM_VEC-1:0]             vec_in,
   input logic                           reg_wr,
   input logic [15:0]                    reg_addr,
   input logic [31:0]                    reg_wdata,
   input logic [NUM_CORES*NUM_PINS-1:0]  irq_out,
   input logic [NUM_VEC-1:0]             raw_flat,
   input logic [NUM_VEC-1:0]             en_flat,
   input logic [NUM_VEC*NUM_CORES-1:0]   stat_flat
);

   localparam int unsigned GROUPS = NUM_VEC / 32;

   logic [NUM_VEC-1:0]                stat_union;
   logic [NUM_VEC-1:0][NUM_CORES-1:0] per_vec;
   logic [NUM_VEC*NUM_CORES-1:0]      clr_flat;
   logic                              stat_wr;

   always_comb begin
      for (int v = 0; v < NUM_VEC; v++) begin
         for (int c = 0; c < NUM_CORES; c++) begin
            per_vec[v][c] = stat_flat[((v / 32) * NUM_CORES + c) * 32 + (v % 32)];
         end
         stat_union[v] = |per_vec[v];
      end
   end

   assign stat_wr = reg_wr && reg_addr[15:10] == 6'd0 && reg_addr[7:5] == 3'd0;

   always_comb begin
      clr_flat = '0;
      for (int g = 0; g < GROUPS; g++) begin
         for (int c = 0; c < NUM_CORES; c++) begin
            if (stat_wr && reg_addr[4:2] == 3'(g) && reg_addr[9:8] == 2'(c))
               clr_flat[(g * NUM_CORES + c) * 32 +: 32] = reg_wdata;
         end
      end
   end

   // R11: state and outputs are clear when reset lifts
   p_reset_clear_r11: assert property (@(posedge clk)
      $rose(rst_n) |-> (irq_out == '0 && stat_flat == '0));

   // R1: raw bits follow the input one edge later
   p_raw_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> raw_flat == $past(vec_in));

   // R1, R3: no status bit without its enable bit
   p_status_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_union & ~en_flat) == '0);

   // R6: no status bit without a high level
   p_status_needs_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_union & ~raw_flat) == '0);

   // R2: an asserted output has some status bit behind it
   p_out_has_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out != '0) |-> (stat_union != '0));

   // R4: written ones are clear afterwards unless a vector rose meanwhile
   p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && (vec_in & ~raw_flat) == '0) |=> (stat_flat & $past(clr_flat)) == '0);

   // R8: a vector never holds status on two cores
   for (genvar v = 0; v < NUM_VEC; v++) begin : g_one
      p_single_core_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(per_vec[v]));
   end

endmodule

bind evr_vector_router evr_router_chk #(
   .NUM_VEC   (NUM_VEC),
   .NUM_CORES (NUM_CORES),
   .NUM_PINS  (NUM_PINS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .vec_in    (vec_in),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .irq_out   (irq_out),
   .raw_flat  (raw_all),
   .en_flat   (en_all),
   .stat_flat (stat_all)
);

// File: tb/evr_vector_router_test.sv
module evr_vector_router_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [255:0] vec_in = '0;
   logic         reg_wr = 1'b0;
   logic [15:0]  reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic [15:0]  irq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   evr_vector_router uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .vec_in    (vec_in),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_out   (irq_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      check(tag, reg_rdata, exp);
   endtask

   task automatic irq_chk(input string tag, input logic [15:0] exp);
      check(tag, {16'b0, irq_out}, {16'b0, exp});
   endtask

   task automatic t_reset();
      irq_chk("R11 outputs low after reset", 16'h0000);
      rd_chk("R11 enable word clear", 16'h0500, 32'h0);
      rd_chk("R11 status word clear", 16'h0000, 32'h0);
      rd_chk("R11 core map clear", 16'h0800, 32'h0);
   endtask

   task automatic t_enable_replay();
      vec_in[5] = 1'b1; step();
      irq_chk("R1 disabled vector stays quiet", 16'h0000);
      rd_chk("R1 no status while disabled", 16'h0000, 32'h0);
      wr(16'h0500, 32'h0000_0020);
      irq_chk("R3 enabling a pending vector raises it", 16'h0001);
      rd_chk("R3 status after replay", 16'h0000, 32'h0000_0020);
      wr(16'h0500, 32'h0000_0021);
      rd_chk("R3 enabling an idle vector sets nothing", 16'h0000, 32'h0000_0020);
      vec_in[0] = 1'b1; step();
      rd_chk("R1 enabled rise sets status", 16'h0000, 32'h0000_0021);
      wr(16'h0500, 32'h0000_0001);
      rd_chk("R3 disabled bit withdrawn only", 16'h0000, 32'h0000_0001);
      irq_chk("R2 output held by remaining vector", 16'h0001);
      wr(16'h0500, 32'h0);
      irq_chk("R2 output drops with last vector", 16'h0000);
      vec_in[0] = 1'b0; vec_in[5] = 1'b0; step();
   endtask

   task automatic t_w1c();
      wr(16'h0500, 32'h0000_00FF);
      vec_in[1] = 1'b1; vec_in[2] = 1'b1; step();
      rd_chk("R4 two pending", 16'h0000, 32'h0000_0006);
      wr(16'h0000, 32'h0000_0002);
      rd_chk("R4 only written one cleared", 16'h0000, 32'h0000_0004);
      irq_chk("R2 still one source", 16'h0001);
      wr(16'h0000, 32'h0000_0004);
      irq_chk("R4 last clear drops output", 16'h0000);
      step(); step();
      irq_chk("R4 held level does not re-raise", 16'h0000);
      vec_in[1] = 1'b0; vec_in[2] = 1'b0; step();
      wr(16'h0500, 32'h0);
   endtask

   task automatic t_fall();
      wr(16'h0500, 32'h0000_0018);
      vec_in[3] = 1'b1; vec_in[4] = 1'b1;
      #1;
      irq_chk("R10 no change before the edge", 16'h0000);
      step();
      irq_chk("R10 output up after one edge", 16'h0001);
      vec_in[3] = 1'b0; step();
      irq_chk("R6 other vector keeps output", 16'h0001);
      rd_chk("R6 fallen status removed", 16'h0000, 32'h0000_0010);
      vec_in[4] = 1'b0; step();
      irq_chk("R6 last fall drops output", 16'h0000);
      wr(16'h0500, 32'h0);
   endtask

   task automatic t_route();
      wr(16'h0400, 32'h0000_0800);
      wr(16'h0828, 32'h0000_0004);
      wr(16'h0504, 32'h0000_0100);
      vec_in[40] = 1'b1; step();
      irq_chk("R7 vector 40 to core 2 pin 3", 16'h0800);
      rd_chk("R5 core 2 group 1 status", 16'h0204, 32'h0000_0100);
      rd_chk("R5 core 0 group 1 status empty", 16'h0004, 32'h0);
      rd_chk("R5 bits 7:5 set decode empty", 16'h0224, 32'h0);
      wr(16'h0828, 32'h0000_0002);
      irq_chk("R8 remap moves output to core 1", 16'h0080);
      rd_chk("R8 status on new core", 16'h0104, 32'h0000_0100);
      rd_chk("R8 status gone from old core", 16'h0204, 32'h0);
      wr(16'h0828, 32'h0000_0010);
      irq_chk("R7 selector bit 4 falls back to core 0", 16'h0008);
      wr(16'h0828, 32'h0000_0000);
      irq_chk("R7 empty byte also core 0, no move", 16'h0008);
      wr(16'h0400, 32'h0);
      irq_chk("R7 empty pin byte selects pin 0", 16'h0001);
      wr(16'h0204, 32'h0000_0100);
      irq_chk("R5 clear aimed at other core ignored", 16'h0001);
      wr(16'h0004, 32'h0000_0100);
      irq_chk("R4 clear on owning core", 16'h0000);
      wr(16'h0504, 32'h0);
      wr(16'h0828, 32'h0000_0004);
      irq_chk("R8 disabled remap raises nothing", 16'h0000);
      wr(16'h0504, 32'h0000_0100);
      irq_chk("R3 enable replays on new core", 16'h0100);
      vec_in[40] = 1'b0; step();
      irq_chk("R6 fall on remapped vector", 16'h0000);
      wr(16'h0504, 32'h0);
      wr(16'h0828, 32'h0);
   endtask

   task automatic t_regs();
      wr(16'h0480, 32'hA5A5_0001);
      rd_chk("R9 node-type word readback", 16'h0480, 32'hA5A5_0001);
      wr(16'h058C, 32'h1234_5678);
      rd_chk("R9 bounce word readback", 16'h058C, 32'h1234_5678);
      wr(16'h08FC, 32'h0102_0408);
      rd_chk("R9 core map readback", 16'h08FC, 32'h0102_0408);
      wr(16'h051C, 32'hFFFF_FFFF);
      rd_chk("R9 enable readback", 16'h051C, 32'hFFFF_FFFF);
      vec_in[252] = 1'b1; step();
      irq_chk("R7 vector 252 to core 3 pin 0", 16'h1000);
      rd_chk("R5 core 3 group 7 status", 16'h031C, 32'h1000_0000);
      vec_in[252] = 1'b0; step();
      wr(16'h0600, 32'hFFFF_FFFF);
      rd_chk("R9 undecoded reads zero", 16'h0600, 32'h0);
      rd_chk("R9 undecoded write left enable alone", 16'h0500, 32'h0);
      irq_chk("R9 undecoded write no output", 16'h0000);
      rd_chk("R9 past window reads zero", 16'h0900, 32'h0);
      rd_chk("R9 high offset reads zero", 16'h1500, 32'h0);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_enable_replay();
      t_w1c();
      t_fall();
      t_route();
      t_regs();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         summary();
         $finish;
      end
   end

endmodule